// File: doc/BRIEF.md
# Two-Wire Register-Map Slave

This block gives a host processor access to a small bank of 8-bit control registers over a two-wire serial bus. A fast system clock samples SCL and SDA through synchronizers and detects the bus conditions and edges on the synchronized lines. The block only pulls SDA low through an open-drain enable; it never drives the line high. The 7-bit device address is fixed except for one bit, which a strap pin sets, so two such slaves can share one bus.

Each transaction starts with the address byte. A write then sends one subaddress byte followed by any number of data bytes, which land in consecutive registers. A read uses a repeated START and continues from the subaddress that the preceding write phase set. Every stored byte produces a one-cycle write strobe with its address and data. Register 0 is a power-control register. Its reset value and bit layout are defined, and it is brought out on a port.

Top module: `i2c_regmap_slave`

## Requirements
- R1: The slave acknowledges an address byte of 0xD4 (write) or 0xD5 (read) while `addr_sel_i` is 0, and 0xD6 or 0xD7 while it is 1. Address bit 1 must equal the strap, bit 0 is R/W with 1 meaning read, and bits 7:2 must be 110101. The acknowledge is SDA held low during the ninth SCL pulse.
- R2: After a non-matching address, the slave does not acknowledge that byte or any later byte, and it stores nothing until the next START.
- R3: In a write, the byte after the address is the subaddress. Each following data byte is acknowledged and stored at the current subaddress, which then increases by one. Each store raises `wr_stb_o` for exactly one clock cycle.
- R4: A subaddress above `MAX_SUB` (default 0x3F) is not acknowledged, and the slave returns to idle.
- R5: A write data byte whose target lies past `MAX_SUB` is not stored and not acknowledged, and the slave goes idle.
- R6: A read after a repeated START returns, MSB first, the register at the latched subaddress and then the following registers. SDA changes only while SCL is low.
- R7: Once a read has passed `MAX_SUB`, every further byte returns register `MAX_SUB`. A master NACK ends the read and releases SDA.
- R8: A START at any point restarts address reception. A STOP at any point returns the slave to idle. A STOP followed by a START within one SCL high period opens a new transaction.
- R9: Register 0 resets to 0x12 and appears on `pwr_ctrl_o`. Its bits are: bit 0 sleep, bit 1 PLL off, bits 2/3/4 enable outputs 3/2/1, and bits 5/6/7 enable outputs 6/5/4. All other registers reset to 0x00, and every register stays writable at all times.
- R10: `sda_oe_o` is 1 only to pull SDA low. It is 0 in reset and after a STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| addr_sel_i | input | 1 | Strap that sets address bit A1 |
| sda_oe_o | output | 1 | 1 = pull SDA low |
| wr_stb_o | output | 1 | One-cycle register write strobe |
| wr_addr_o | output | 8 | Register address of the current write |
| wr_data_o | output | 8 | Data of the current write |
| pwr_ctrl_o | output | 8 | Contents of register 0 |

## Verification
The bench walks every address byte under both strap settings. A slave that decoded the strap into the wrong bit would acknowledge the other device's address. The range tests write and read at `MAX_SUB` and then one byte past it. A design with an off-by-one error at the top of the range would store the overflow byte, or would return register 0 instead of repeating the highest register. The bench also breaks off a byte halfway with a STOP or a START, and it issues a STOP-then-START within one SCL high period. A slave that kept its bit count across these events would store garbage or miss the next address.

// File: rtl/i2c_regmap_pkg.sv
package i2c_regmap_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_SUB,
    ST_WDATA,
    ST_ACK,
    ST_RDATA,
    ST_RACK
  } slv_state_e;

  localparam logic [5:0] DEV_ADDR_HI = 6'b110101;
  localparam logic [7:0] PWR_RST     = 8'h12;
endpackage

// File: rtl/i2c_bus_sync.sv
module i2c_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s_o,
  output logic sda_s_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_prev, sda_prev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff   <= '1;
      sda_ff   <= '1;
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_ff   <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff   <= {sda_ff[STAGES-2:0], sda_i};
      scl_prev <= scl_ff[STAGES-1];
      sda_prev <= sda_ff[STAGES-1];
    end
  end

  assign scl_s_o    = scl_ff[STAGES-1];
  assign sda_s_o    = sda_ff[STAGES-1];
  assign scl_rise_o = scl_s_o & ~scl_prev;
  assign scl_fall_o = ~scl_s_o & scl_prev;
  // bus conditions only while SCL is stably high
  assign start_o    = scl_s_o & scl_prev & sda_prev & ~sda_s_o;
  assign stop_o     = scl_s_o & scl_prev & ~sda_prev & sda_s_o;
endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank #(
  parameter int         NREG    = 64,
  parameter logic [7:0] RST_REG0 = 8'h12
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [7:0] waddr_i,
  input  logic [7:0] wdata_i,
  input  logic [7:0] raddr_i,
  output logic [7:0] rdata_o,
  output logic [7:0] reg0_o
);
  localparam int IW = (NREG > 1) ? $clog2(NREG) : 1;

  logic [7:0] regs [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam logic [7:0] RV = (i == 0) ? RST_REG0 : 8'h00;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          regs[i] <= RV;
      else if (we_i && waddr_i == 8'(i))    regs[i] <= wdata_i;
    end
  end

  assign rdata_o = regs[raddr_i[IW-1:0]];
  assign reg0_o  = regs[0];
endmodule

// File: rtl/i2c_slave_fsm.sv
module i2c_slave_fsm
  import i2c_regmap_pkg::*;
#(
  parameter logic [7:0] MAX_SUB = 8'h3F
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sda_s_i,
  input  logic       scl_rise_i,
  input  logic       scl_fall_i,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic       addr_sel_i,
  input  logic [7:0] rd_data_i,
  output logic [7:0] rd_addr_o,
  output logic       sda_oe_o,
  output logic       wr_stb_o,
  output logic [7:0] wr_addr_o,
  output logic [7:0] wr_data_o
);
  localparam logic [8:0] MAX_PTR = {1'b0, MAX_SUB};

  slv_state_e st_q, after_q;
  logic [7:0] sh_q;
  logic [3:0] cnt_q;
  logic [8:0] ptr_q;
  logic       mack_q;

  logic addr_hit, ptr_ok;
  assign addr_hit  = (sh_q[7:2] == DEV_ADDR_HI) && (sh_q[1] == addr_sel_i);
  assign ptr_ok    = (ptr_q <= MAX_PTR);
  assign rd_addr_o = ptr_ok ? ptr_q[7:0] : MAX_SUB;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      after_q   <= ST_IDLE;
      sh_q      <= '0;
      cnt_q     <= '0;
      ptr_q     <= '0;
      mack_q    <= 1'b0;
      sda_oe_o  <= 1'b0;
      wr_stb_o  <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
    end else begin
      wr_stb_o <= 1'b0;
      if (start_i) begin
        st_q     <= ST_ADDR;
        cnt_q    <= '0;
        sda_oe_o <= 1'b0;
      end else if (stop_i) begin
        st_q     <= ST_IDLE;
        sda_oe_o <= 1'b0;
      end else begin
        unique case (st_q)
          ST_IDLE: ;
          ST_ADDR, ST_SUB, ST_WDATA: begin
            if (scl_rise_i) begin
              sh_q  <= {sh_q[6:0], sda_s_i};
              cnt_q <= cnt_q + 4'd1;
            end else if (scl_fall_i && cnt_q == 4'd8) begin
              cnt_q <= '0;
              st_q  <= ST_IDLE;
              if (st_q == ST_ADDR && addr_hit) begin
                sda_oe_o <= 1'b1;
                after_q  <= sh_q[0] ? ST_RDATA : ST_SUB;
                st_q     <= ST_ACK;
              end else if (st_q == ST_SUB && sh_q <= MAX_SUB) begin
                ptr_q    <= {1'b0, sh_q};
                sda_oe_o <= 1'b1;
                after_q  <= ST_WDATA;
                st_q     <= ST_ACK;
              end else if (st_q == ST_WDATA && ptr_ok) begin
                wr_stb_o  <= 1'b1;
                wr_addr_o <= ptr_q[7:0];
                wr_data_o <= sh_q;
                ptr_q     <= ptr_q + 9'd1;
                sda_oe_o  <= 1'b1;
                after_q   <= ST_WDATA;
                st_q      <= ST_ACK;
              end
            end
          end
          ST_ACK: begin
            if (scl_fall_i) begin
              cnt_q <= '0;
              st_q  <= after_q;
              if (after_q == ST_RDATA) begin
                sh_q     <= rd_data_i;
                sda_oe_o <= ~rd_data_i[7];
              end else begin
                sda_oe_o <= 1'b0;
              end
            end
          end
          ST_RDATA: begin
            if (scl_rise_i) begin
              cnt_q <= cnt_q + 4'd1;
            end else if (scl_fall_i) begin
              if (cnt_q == 4'd8) begin
                sda_oe_o <= 1'b0;
                st_q     <= ST_RACK;
              end else begin
                sh_q     <= {sh_q[6:0], 1'b0};
                sda_oe_o <= ~sh_q[6];
              end
            end
          end
          ST_RACK: begin
            if (scl_rise_i) begin
              mack_q <= ~sda_s_i;
              // advance before the fall so the next byte is ready; saturate at top
              if (!sda_s_i && ptr_q < MAX_PTR) ptr_q <= ptr_q + 9'd1;
            end else if (scl_fall_i) begin
              cnt_q <= '0;
              if (mack_q) begin
                sh_q     <= rd_data_i;
                sda_oe_o <= ~rd_data_i[7];
                st_q     <= ST_RDATA;
              end else begin
                st_q <= ST_IDLE;
              end
            end
          end
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_regmap_slave.sv
module i2c_regmap_slave
  import i2c_regmap_pkg::*;
#(
  parameter logic [7:0] MAX_SUB     = 8'h3F,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic       addr_sel_i,
  output logic       sda_oe_o,
  output logic       wr_stb_o,
  output logic [7:0] wr_addr_o,
  output logic [7:0] wr_data_o,
  output logic [7:0] pwr_ctrl_o
);
  localparam int NREG = int'(MAX_SUB) + 1;

  logic scl_sync, sda_sync, scl_rise, scl_fall, start_evt, stop_evt;
  logic [7:0] rd_addr, rd_data;

  i2c_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_s_o    (scl_sync),
    .sda_s_o    (sda_sync),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_evt),
    .stop_o     (stop_evt)
  );

  i2c_slave_fsm #(.MAX_SUB(MAX_SUB)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sda_s_i    (sda_sync),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (start_evt),
    .stop_i     (stop_evt),
    .addr_sel_i (addr_sel_i),
    .rd_data_i  (rd_data),
    .rd_addr_o  (rd_addr),
    .sda_oe_o   (sda_oe_o),
    .wr_stb_o   (wr_stb_o),
    .wr_addr_o  (wr_addr_o),
    .wr_data_o  (wr_data_o)
  );

  i2c_reg_bank #(.NREG(NREG), .RST_REG0(PWR_RST)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_stb_o),
    .waddr_i (wr_addr_o),
    .wdata_i (wr_data_o),
    .raddr_i (rd_addr),
    .rdata_o (rd_data),
    .reg0_o  (pwr_ctrl_o)
  );
endmodule

// File: rtl/i2c_regmap_slave_chk.sv
module i2c_regmap_slave_chk #(
  parameter logic [7:0] MAX_SUB = 8'h3F
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       scl_s,
  input logic       stop_det,
  input logic       sda_oe_o,
  input logic       wr_stb_o,
  input logic [7:0] wr_addr_o,
  input logic [7:0] pwr_ctrl_o
);
  AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> !scl_s); // R6

  AST_WR_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb_o |-> wr_addr_o <= MAX_SUB); // R5

  AST_STB_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb_o |=> !wr_stb_o); // R3

  AST_PWR_ONLY_BY_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(pwr_ctrl_o) |-> $past(wr_stb_o && wr_addr_o == 8'h00)); // R9

  AST_STOP_RELEASES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> !sda_oe_o); // R10
endmodule

bind i2c_regmap_slave i2c_regmap_slave_chk #(.MAX_SUB(MAX_SUB)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .scl_s      (scl_sync),
  .stop_det   (stop_evt),
  .sda_oe_o   (sda_oe_o),
  .wr_stb_o   (wr_stb_o),
  .wr_addr_o  (wr_addr_o),
  .pwr_ctrl_o (pwr_ctrl_o)
);

// File: tb/sim_i2c_regmap_slave.sv
module sim_i2c_regmap_slave;
  localparam int CLK_PERIOD = 10;
  localparam int H = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1, strap = 1'b0;
  logic sda_oe, wr_stb;
  logic [7:0] wr_addr, wr_data, pwr;
  wire  sda_line = m_sda & ~sda_oe;

  int n_chk = 0, n_fail = 0, stb_cnt = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_regmap_slave u0 (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(m_scl), .sda_i(sda_line),
    .addr_sel_i(strap), .sda_oe_o(sda_oe), .wr_stb_o(wr_stb),
    .wr_addr_o(wr_addr), .wr_data_o(wr_data), .pwr_ctrl_o(pwr)
  );

  always @(posedge clk) if (wr_stb) stb_cnt <= stb_cnt + 1;

  task automatic wt(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic bit_out(logic b);
    m_sda = b; wt(H); m_scl = 1'b1; wt(H); m_scl = 1'b0; wt(2);
  endtask

  task automatic do_start();
    m_sda = 1'b1; wt(H); m_scl = 1'b1; wt(H); m_sda = 1'b0; wt(H); m_scl = 1'b0; wt(2);
  endtask

  task automatic do_stop();
    m_sda = 1'b0; wt(H); m_scl = 1'b1; wt(H); m_sda = 1'b1; wt(H);
  endtask

  task automatic wb(logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
    m_sda = 1'b1; wt(H); m_scl = 1'b1; wt(H/2);
    ack = ~sda_line;
    wt(H/2); m_scl = 1'b0; wt(2);
  endtask

  task automatic rb(logic mack, output logic [7:0] d);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wt(H); m_scl = 1'b1; wt(H/2); d[i] = sda_line; wt(H/2); m_scl = 1'b0; wt(2);
    end
    bit_out(~mack);
    m_sda = 1'b1;
  endtask

  // {strap, address byte, expected ack}
  localparam logic [9:0] VEC [8] = '{
    {1'b0, 8'hD4, 1'b1}, {1'b0, 8'hD5, 1'b1}, {1'b0, 8'hD6, 1'b0}, {1'b0, 8'h54, 1'b0},
    {1'b1, 8'hD6, 1'b1}, {1'b1, 8'hD7, 1'b1}, {1'b1, 8'hD4, 1'b0}, {1'b1, 8'hD0, 1'b0}
  };

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      summary();
    end
  end

  initial begin
    logic a;
    logic [7:0] d;
    int s0;
    wt(5); rst_n = 1'b1; wt(5);
    chk(pwr == 8'h12, "R9 reset value", pwr, 8'h12);
    chk(sda_oe == 1'b0, "R10 released in reset", sda_oe, 0);

    foreach (VEC[k]) begin
      strap = VEC[k][9]; wt(4);
      do_start(); wb(VEC[k][8:1], a);
      chk(a == VEC[k][0], "R1 address decode", a, VEC[k][0]);
      if (a && VEC[k][1]) rb(1'b0, d);
      do_stop();
    end
    strap = 1'b0; wt(4);

    s0 = stb_cnt;
    do_start(); wb(8'hD4, a); wb(8'h00, a);
    wb(8'hA5, a); chk(a, "R3 data ack", a, 1);
    wb(8'h3C, a); wb(8'hC3, a); do_stop();
    chk(pwr == 8'hA5, "R9 power register write", pwr, 8'hA5);
    chk(stb_cnt - s0 == 3, "R3 one strobe per byte", stb_cnt - s0, 3);

    do_start(); wb(8'hD4, a); wb(8'h01, a);
    do_start(); wb(8'hD5, a); chk(a, "R6 read address ack", a, 1);
    rb(1'b1, d); chk(d == 8'h3C, "R6 read latched subaddress", d, 8'h3C);
    rb(1'b0, d); chk(d == 8'hC3, "R6 read increments", d, 8'hC3);
    do_stop();

    s0 = stb_cnt;
    do_start(); wb(8'hD4, a); wb(8'h40, a);
    chk(!a, "R4 invalid subaddress nack", a, 0);
    do_stop();
    chk(stb_cnt == s0, "R4 nothing stored", stb_cnt - s0, 0);

    do_start(); wb(8'hD4, a); wb(8'h3F, a);
    wb(8'h77, a); chk(a, "R5 top register ack", a, 1);
    wb(8'h88, a); chk(!a, "R5 past top nack", a, 0);
    do_stop();
    chk(stb_cnt - s0 == 1, "R5 overflow byte not stored", stb_cnt - s0, 1);

    do_start(); wb(8'hD4, a); wb(8'h3E, a);
    do_start(); wb(8'hD5, a);
    rb(1'b1, d); chk(d == 8'h00, "R9 other registers reset zero", d, 0);
    rb(1'b1, d); chk(d == 8'h77, "R7 top register", d, 8'h77);
    rb(1'b1, d); chk(d == 8'h77, "R7 repeat top", d, 8'h77);
    rb(1'b0, d); chk(d == 8'h77, "R7 repeat top again", d, 8'h77);
    wt(4); chk(sda_oe == 1'b0, "R7 nack releases SDA", sda_oe, 0);
    do_stop();

    s0 = stb_cnt;
    do_start(); wb(8'hD4, a); wb(8'h05, a);
    bit_out(1'b1); bit_out(1'b0); bit_out(1'b1); bit_out(1'b0);
    do_stop();
    chk(stb_cnt == s0, "R8 stop mid byte", stb_cnt - s0, 0);
    do_start(); wb(8'hD4, a); wb(8'h06, a);
    bit_out(1'b0); bit_out(1'b1); bit_out(1'b1);
    do_start(); wb(8'hD4, a); chk(a, "R8 start mid byte restarts", a, 1);
    wb(8'h07, a); wb(8'h5A, a);
    // stop then start in one SCL high period
    m_sda = 1'b0; wt(H); m_scl = 1'b1; wt(H); m_sda = 1'b1; wt(H);
    m_sda = 1'b0; wt(H); m_scl = 1'b0; wt(2);
    wb(8'hD5, a); chk(a, "R8 stop-start in one high period", a, 1);
    rb(1'b0, d); do_stop();
    do_start(); wb(8'hD4, a); wb(8'h05, a);
    do_start(); wb(8'hD5, a);
    rb(1'b1, d); chk(d == 8'h00, "R8 aborted byte not stored", d, 0);
    rb(1'b1, d); chk(d == 8'h00, "R8 aborted byte not stored 06", d, 0);
    rb(1'b0, d); chk(d == 8'h5A, "R8 write after restart", d, 8'h5A);
    do_stop();

    s0 = stb_cnt;
    do_start(); wb(8'hD6, a); chk(!a, "R2 foreign address nack", a, 0);
    wb(8'h00, a); chk(!a, "R2 following byte nack", a, 0);
    wb(8'hFF, a); do_stop();
    chk(stb_cnt == s0, "R2 no strobe", stb_cnt - s0, 0);
    chk(pwr == 8'hA5, "R2 register untouched", pwr, 8'hA5);

    rst_n = 1'b0; wt(2);
    chk(pwr == 8'h12, "R9 reset restores", pwr, 8'h12);
    chk(sda_oe == 1'b0, "R10 reset releases", sda_oe, 0);
    rst_n = 1'b1; wt(4);

    done = 1;
    summary();
  end
endmodule